// File: doc/BRIEF.md
# End-of-Write Status Poller

This block sits on the host side of a parallel flash. It decides when an internally timed program or erase has finished. It starts once the command issue logic has delivered the last write pulse of the sequence. For a program that is the fourth pulse, and for an erase it is the sixth. Status reads are meaningful only after that point.

A start request carries four things: the target address, the word that was programmed, whether the operation is a program or an erase, and which status method to use. The poller then issues repeated reads of that address on a request/response read port.

There are two status methods:
- **Data-complement method.** While a program is busy, bit 7 of every read is the inverse of bit 7 of the word being written. While an erase is busy, bit 7 reads 0. Completion is seen as the true bit 7 for a program, or a 1 for an erase.
- **Toggle method.** While either operation is busy, bit 6 flips on every read. Two back-to-back reads with the same bit 6 are taken as a candidate completion.

The internal write ends at a time unrelated to the read sequence, so a single read that looks complete can be wrong. Every candidate must be backed by two more reads of the same location that also look complete. If either of them does not, the candidate is rejected and polling resumes. After confirmation, the low data bits may still be settling. The poller waits a programmable number of cycles, does one final full-word read, returns that word and pulses done. A programmable limit on status reads ends a stuck operation with a timeout pulse.

Top module: `eow_poller`

States and transitions:
- **IDLE** goes to **POLL_REQ** on start.
- **POLL_REQ** issues a status read and goes to **POLL_WAIT**. If the read limit is already reached, it goes to **TOUT** instead.
- **POLL_WAIT**, on the response, goes to **CONF_REQ** for a candidate. Otherwise it returns to **POLL_REQ**.
- **CONF_REQ** issues a confirming read and goes to **CONF_WAIT**, or goes to **TOUT** at the limit.
- **CONF_WAIT**, on the response, goes to **CONF_REQ** after the first good confirmation and to **SETTLE** after the second. It falls back to **POLL_REQ** on a bad one.
- **SETTLE** goes to **FINAL_REQ** when its timer expires.
- **FINAL_REQ** goes to **FINAL_WAIT**.
- **FINAL_WAIT** goes to **DONE** on the response.
- **DONE** and **TOUT** each last one cycle and return to **IDLE**.

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `rd_req` are all 0.
- R2: In program mode with the data-complement method (`use_toggle`=0, `op_erase`=0), a status read counts as complete when its bit 7 equals bit 7 of `exp_data`.
- R3: In erase mode with the data-complement method, a status read counts as complete when its bit 7 is 1. The returned result for a finished erase is the all-ones word supplied by the flash.
- R4: With `use_toggle`=1, a status read counts as complete when its bit 6 equals bit 6 of the previous status read of the same run. The first read of a run is never a candidate.
- R5: A candidate is accepted only when the next two status reads also count as complete. A failed confirmation sends the poller back to polling, and `done` is never raised while the flash is still busy.
- R6: After confirmation, no read is issued for at least `settle_cycles` cycles. Then one final read is made, and its word appears on `result_data` in the cycle `done` is 1.
- R7: When `max_polls` status reads have been issued without a confirmed completion, `timeout` pulses for one cycle. No further read is issued and the poller returns to idle.
- R8: `start` is ignored while `busy` is 1. The running operation keeps its address and expected data.
- R9: Every read request carries the address latched at start. At most one read is outstanding, so `rd_req` is never high in two consecutive cycles.
- R10: `done` and `timeout` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a status run (taken only when idle) |
| op_erase | input | 1 | 1 = erase in progress, 0 = program |
| use_toggle | input | 1 | 1 = toggle method, 0 = data-complement method |
| tgt_addr | input | ADDR_W | Address to poll |
| exp_data | input | DATA_W | Word that was programmed |
| settle_cycles | input | SETTLE_W | Wait before the final read |
| max_polls | input | POLL_W | Status read limit |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Read response word |
| busy | output | 1 | A run is active |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Limit reached pulse |
| result_data | output | DATA_W | Word from the final read |

## Verification
The bench builds the block with a 16-bit data path, a 20-bit address, an 8-bit poll limit and a 6-bit settle count. These small widths put the timeout limit within reach. A limit of six reads exhausts in a few dozen cycles. A settle value of 20 is long enough to outlast the model's ten-cycle window of unsettled low bits after completion, so the final word is clean. The flash model can inject one false completion read while still busy, in both methods. That exercises the rejection path and shows that done never precedes the real end of the write.

// File: rtl/eow_pkg.sv
package eow_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_CONF_REQ,
        ST_CONF_WAIT,
        ST_SETTLE,
        ST_FINAL_REQ,
        ST_FINAL_WAIT,
        ST_DONE,
        ST_TOUT
    } eow_state_e;

endpackage

// File: rtl/eow_judge.sv
// Decides whether one status word looks like a finished write.
module eow_judge #(
    parameter int DATA_W   = 16,
    parameter int BUSY_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [DATA_W-1:0] word,
    input  logic              exp_bit,
    input  logic              op_erase,
    input  logic              use_toggle,
    output logic              looks_done
);

    logic prev_tog;
    logic have_prev;
    logic poll_ok;
    logic tog_ok;

    // data-complement method: erase finishes at 1, program at the true bit
    always_comb begin
        if (op_erase) poll_ok = word[BUSY_BIT];
        else          poll_ok = (word[BUSY_BIT] == exp_bit);
    end

    // toggle method: bit unchanged from the previous status read
    always_comb tog_ok = have_prev && (word[TOG_BIT] == prev_tog);

    always_comb looks_done = use_toggle ? tog_ok : poll_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tog  <= 1'b0;
            have_prev <= 1'b0;
        end else if (clear) begin
            have_prev <= 1'b0;
        end else if (sample) begin
            prev_tog  <= word[TOG_BIT];
            have_prev <= 1'b1;
        end
    end

    // R4
    first_read_no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !have_prev);

endmodule

// File: rtl/eow_poll_ctr.sv
// Counts status reads of one run against the latched limit.
module eow_poll_ctr #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [POLL_W-1:0] limit,
    output logic [POLL_W-1:0] count,
    output logic              lim_hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= count + 1'b1;
    end

    always_comb lim_hit = (count >= limit);

    // R7
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |-> (count < limit));

endmodule

// File: rtl/eow_settle_tmr.sv
// Down-counter that holds off the final read.
module eow_settle_tmr #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] load_val,
    output logic                expired
);

    logic [SETTLE_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             remain <= '0;
        else if (load)          remain <= load_val;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    always_comb expired = (remain == '0);

endmodule

// File: rtl/eow_poller.sv
module eow_poller
    import eow_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int ADDR_W        = 21,
    parameter int POLL_W        = 16,
    parameter int SETTLE_W      = 8,
    parameter int BUSY_BIT      = 7,
    parameter int TOG_BIT       = 6,
    parameter int CONFIRM_READS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op_erase,
    input  logic                use_toggle,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [DATA_W-1:0]   exp_data,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [POLL_W-1:0]   max_polls,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_valid,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                busy,
    output logic                done,
    output logic                timeout,
    output logic [DATA_W-1:0]   result_data
);

    localparam int CONF_W = $clog2(CONFIRM_READS + 1);
    localparam logic [CONF_W-1:0] CONF_LAST = CONF_W'(CONFIRM_READS - 1);

    eow_state_e st, nxt;

    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   exp_q;
    logic                erase_q;
    logic                tog_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [POLL_W-1:0]   max_q;
    logic [CONF_W-1:0]   conf_cnt;
    logic [POLL_W-1:0]   poll_cnt;

    logic accept;
    logic looks_done;
    logic lim_hit;
    logic settle_zero;
    logic status_issue;
    logic status_resp;
    logic conf_last;
    logic settle_load;

    always_comb accept      = (st == ST_IDLE) && start;
    always_comb conf_last   = (conf_cnt == CONF_LAST);
    always_comb status_resp = rd_valid && ((st == ST_POLL_WAIT) || (st == ST_CONF_WAIT));
    always_comb settle_load = (st == ST_CONF_WAIT) && rd_valid && looks_done && conf_last;

    eow_judge #(
        .DATA_W   (DATA_W),
        .BUSY_BIT (BUSY_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .sample     (status_resp),
        .word       (rd_data),
        .exp_bit    (exp_q[BUSY_BIT]),
        .op_erase   (erase_q),
        .use_toggle (tog_q),
        .looks_done (looks_done)
    );

    eow_poll_ctr #(
        .POLL_W (POLL_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (status_issue),
        .limit   (max_q),
        .count   (poll_cnt),
        .lim_hit (lim_hit)
    );

    eow_settle_tmr #(
        .SETTLE_W (SETTLE_W)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_q),
        .expired  (settle_zero)
    );

    // state register and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            addr_q      <= '0;
            exp_q       <= '0;
            erase_q     <= 1'b0;
            tog_q       <= 1'b0;
            settle_q    <= '0;
            max_q       <= '0;
            conf_cnt    <= '0;
            result_data <= '0;
        end else begin
            st <= nxt;
            if (accept) begin
                addr_q   <= tgt_addr;
                exp_q    <= exp_data;
                erase_q  <= op_erase;
                tog_q    <= use_toggle;
                settle_q <= settle_cycles;
                max_q    <= max_polls;
            end
            if ((st == ST_POLL_WAIT) && rd_valid)
                conf_cnt <= '0;
            else if ((st == ST_CONF_WAIT) && rd_valid && looks_done)
                conf_cnt <= conf_cnt + 1'b1;
            if ((st == ST_FINAL_WAIT) && rd_valid)
                result_data <= rd_data;
        end
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:       if (start) nxt = ST_POLL_REQ;
            ST_POLL_REQ:   nxt = lim_hit ? ST_TOUT : ST_POLL_WAIT;
            ST_POLL_WAIT:  if (rd_valid) nxt = looks_done ? ST_CONF_REQ : ST_POLL_REQ;
            ST_CONF_REQ:   nxt = lim_hit ? ST_TOUT : ST_CONF_WAIT;
            ST_CONF_WAIT: begin
                if (rd_valid) begin
                    if (!looks_done)    nxt = ST_POLL_REQ;
                    else if (conf_last) nxt = ST_SETTLE;
                    else                nxt = ST_CONF_REQ;
                end
            end
            ST_SETTLE:     if (settle_zero) nxt = ST_FINAL_REQ;
            ST_FINAL_REQ:  nxt = ST_FINAL_WAIT;
            ST_FINAL_WAIT: if (rd_valid) nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            ST_TOUT:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        status_issue = 1'b0;
        rd_req       = 1'b0;
        done         = 1'b0;
        timeout      = 1'b0;
        busy         = (st != ST_IDLE);
        rd_addr      = addr_q;
        unique case (st)
            ST_POLL_REQ, ST_CONF_REQ: begin
                status_issue = !lim_hit;
                rd_req       = !lim_hit;
            end
            ST_FINAL_REQ: rd_req  = 1'b1;
            ST_DONE:      done    = 1'b1;
            ST_TOUT:      timeout = 1'b1;
            default: ;
        endcase
    end

    // R10
    done_tout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R7
    tout_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (poll_cnt == max_q));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(addr_q) && $stable(exp_q)));

endmodule

// File: tb/sim_eow_poller.sv
module sim_eow_poller;

    localparam int DW = 16;
    localparam int AW = 20;
    localparam int PW = 8;
    localparam int SW = 6;
    localparam int GARBLE = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          start, op_erase, use_toggle;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] exp_data;
    logic [SW-1:0] settle_cycles;
    logic [PW-1:0] max_polls;
    logic          rd_req, rd_valid, busy, done, timeout;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data, result_data;

    eow_poller #(.DATA_W(DW), .ADDR_W(AW), .POLL_W(PW), .SETTLE_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .use_toggle(use_toggle), .tgt_addr(tgt_addr), .exp_data(exp_data),
        .settle_cycles(settle_cycles), .max_polls(max_polls),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .timeout(timeout), .result_data(result_data));

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    // model and monitor state
    logic          m_erase, m_tgl, m_tog, pend;
    logic [DW-1:0] m_true;
    logic [AW-1:0] m_addr;
    int            m_tdone, m_glitch, m_rdidx;
    int            reads, last_req, prev_req, fin_cyc;
    logic          finished;
    logic [DW:0]   sb_q[$];

    task automatic check(input logic ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // flash model and monitor, both on the falling edge
    always @(negedge clk) begin
        logic [DW-1:0] d;
        logic [DW:0]   e;
        rd_valid = 1'b0;
        if (pend) begin
            if (cyc < m_tdone) begin
                d = 16'h3C5A;
                d[7] = m_erase ? 1'b0 : ~m_true[7];
                if (m_rdidx == m_glitch) begin
                    if (!m_tgl) d[7] = m_erase ? 1'b1 : m_true[7];
                end else begin
                    m_tog = ~m_tog;
                end
                d[6] = m_tog;
            end else if (cyc < m_tdone + GARBLE) begin
                d = m_true ^ 16'h0F3F;
            end else begin
                d = m_true;
            end
            m_rdidx++;
            rd_data  = d;
            rd_valid = 1'b1;
            pend = 1'b0;
        end
        if (rd_req) begin
            pend = 1'b1;
            reads++;
            prev_req = last_req;
            last_req = cyc;
            // R9
            check(rd_addr == m_addr, "R9 read address", rd_addr, m_addr);
        end
        if (done || timeout) begin
            // R10
            check(!(done && timeout), "R10 done and timeout together", {done, timeout}, 2'b10);
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", {timeout, result_data}, 0);
            end else begin
                e = sb_q.pop_front();
                check({timeout, done ? result_data : 16'h0} == e,
                      "R2/R3/R6/R7 result", {timeout, done ? result_data : 16'h0}, e);
            end
            fin_cyc = cyc;
            finished = 1'b1;
        end
    end

    task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] x, input logic er,
                          input logic tg, input int st, input int mp, input int blen,
                          input int glitch, input logic exp_tout, input logic poke,
                          input string tag);
        int wd;
        @(negedge clk);
        m_erase = er; m_tgl = tg; m_true = er ? 16'hFFFF : x; m_addr = a;
        m_tdone = cyc + blen; m_glitch = glitch; m_rdidx = 0; m_tog = 1'b0;
        reads = 0; last_req = 0; prev_req = 0; finished = 1'b0;
        sb_q.push_back(exp_tout ? {1'b1, 16'h0} : {1'b0, m_true});
        tgt_addr = a; exp_data = x; op_erase = er; use_toggle = tg;
        settle_cycles = SW'(st); max_polls = PW'(mp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            // R8: a second start with other values while busy
            check(busy == 1'b1, "R8 busy during run", busy, 1);
            tgt_addr = ~a; exp_data = ~x; op_erase = ~er; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!finished && wd < 3000) begin
            @(negedge clk);
            wd++;
        end
        check(finished, {tag, " watchdog"}, wd, 0);
        if (finished && !exp_tout) begin
            // R5: done never while the flash is still busy
            check(fin_cyc > m_tdone, {tag, " R5 done after completion"}, fin_cyc, m_tdone);
            // R6: idle gap before the final read
            check(last_req - prev_req >= st, {tag, " R6 settle gap"}, last_req - prev_req, st);
        end
        if (finished && exp_tout)
            check(reads == mp, {tag, " R7 read count"}, reads, mp);
        @(negedge clk);
        check(!busy && !done && !timeout, {tag, " back to idle"}, busy, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; op_erase = 1'b0; use_toggle = 1'b0;
        tgt_addr = '0; exp_data = '0; settle_cycles = '0; max_polls = '0;
        rd_valid = 1'b0; rd_data = '0; pend = 1'b0; finished = 1'b0;
        m_erase = 1'b0; m_tgl = 1'b0; m_tog = 1'b0; m_true = '0; m_addr = '0;
        m_tdone = 0; m_glitch = -1; m_rdidx = 0; reads = 0; last_req = 0; prev_req = 0;
        fin_cyc = 0;
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !done && !timeout && !rd_req, "R1 reset state",
              {busy, done, timeout, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !rd_req, "R1 idle after reset", {busy, rd_req}, 0);

        run_op(20'h1A2B3, 16'hA5C3, 1'b0, 1'b0, 20, 60, 50, -1, 1'b0, 1'b0, "R2 prog poll b7=1");
        run_op(20'h00457, 16'h1234, 1'b0, 1'b0, 20, 60, 40, -1, 1'b0, 1'b0, "R2 prog poll b7=0");
        run_op(20'hF0800, 16'h0000, 1'b1, 1'b0, 20, 60, 70, -1, 1'b0, 1'b0, "R3 erase poll");
        run_op(20'h33333, 16'h5A96, 1'b0, 1'b1, 20, 60, 45, -1, 1'b0, 1'b0, "R4 prog toggle");
        run_op(20'h44000, 16'h0000, 1'b1, 1'b1, 20, 60, 55, -1, 1'b0, 1'b0, "R4 erase toggle");
        run_op(20'h12345, 16'hC3A5, 1'b0, 1'b0, 20, 60, 60,  3, 1'b0, 1'b0, "R5 glitch poll");
        run_op(20'h54321, 16'h6B1D, 1'b0, 1'b1, 20, 60, 60,  3, 1'b0, 1'b0, "R5 glitch toggle");
        run_op(20'h0F0F0, 16'h0000, 1'b1, 1'b0, 20, 60, 65,  2, 1'b0, 1'b0, "R5 glitch erase");
        run_op(20'h77777, 16'h8001, 1'b0, 1'b0, 20,  6, 100000, -1, 1'b1, 1'b0, "R7 timeout");
        run_op(20'h2468A, 16'h9E37, 1'b0, 1'b0, 20, 60, 50, -1, 1'b0, 1'b1, "R8 start while busy");
        run_op(20'h13579, 16'h7F80, 1'b0, 1'b1, 30, 60, 30, -1, 1'b0, 1'b0, "R6 long settle");

        check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule